// File: doc/BRIEF.md
# Banked Program Memory Address Mapper

This block sits between a small controller's program counter and a 16 KiB byte-wide program store built from four 4 KiB banks. A 13-bit fetch address is turned into a 14-bit physical address. The lower half of the fetch space always goes to bank 0. The upper half is a window that a 2-bit bank register steers onto bank 1, 2 or 3. The code 11 is reserved: it is mapped as bank 3 and sets a sticky error flag that only reset clears.

The block also serves table lookups through a 12-bit data pointer. The pointer is loaded one nibble at a time. A lookup always addresses the upper window, at window offset equal to the pointer, inside the bank that is selected at that moment. A low-nibble lookup returns bits 3:0 of the byte and leaves the pointer alone. A high-nibble lookup returns bits 7:4 and then advances the pointer by one. The pointer wraps from FFFh to 000h. The memory has one read port. A lookup takes that port for the cycle of the command, and the result is registered and shown on the next cycle.

Top module: `prog_bank_mapper`

## Requirements
- R1: After reset the bank register is 00, the error flag is 0, the pointer is 000h and the nibble result is 0.
- R2: When no lookup is issued, a fetch address with bit 12 = 0 drives mem_addr = {2'b00, pc[11:0]} in the same cycle.
- R3: When no lookup is issued, a fetch address with bit 12 = 1 drives mem_addr = {bank+1, pc[11:0]} for bank codes 00, 01 and 10, giving banks 1, 2 and 3.
- R4: A write of the bank register (bank_we high) takes effect from the next cycle, and reads back on bank_q.
- R5: Bank code 11 maps the window to bank 3 and sets err_rsvd. err_rsvd stays set after the code is changed, until reset.
- R6: Each of the three nibble loads writes only its own nibble: low is bits 3:0, middle is bits 7:4, high is bits 11:8 of the pointer.
- R7: During a lookup, mem_addr = {bank code mapped as in R3/R5, dptr}. This is the physical address of logical 1000h+dptr.
- R8: A low lookup gives nib_q = mem_rdata[3:0] one cycle later, and the pointer does not change.
- R9: A high lookup gives nib_q = mem_rdata[7:4] one cycle later, and the pointer then reads one higher.
- R10: A high lookup at pointer FFFh leaves the pointer at 000h.
- R11: If low and high lookups are both requested in one cycle, the high lookup wins. A nibble load in the same cycle as a high lookup takes priority over the increment for the nibble it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | 13 | Fetch address |
| bank_we | input | 1 | Bank register write strobe |
| bank_wd | input | 2 | Bank register write data |
| bank_q | output | 2 | Current bank code |
| err_rsvd | output | 1 | Sticky reserved-code flag |
| dp_ld_lo | input | 1 | Load pointer bits 3:0 |
| dp_ld_mid | input | 1 | Load pointer bits 7:4 |
| dp_ld_hi | input | 1 | Load pointer bits 11:8 |
| dp_wd | input | 4 | Nibble load data |
| dptr_q | output | 12 | Current pointer |
| rd_lo | input | 1 | Low-nibble lookup |
| rd_hi | input | 1 | High-nibble lookup with increment |
| mem_addr | output | 14 | Physical memory address |
| mem_rdata | input | 8 | Memory read byte (combinational) |
| nib_q | output | 4 | Lookup result to accumulator |

## Verification
The hardest case to reach is the pointer wrap at FFFh together with the carry through all three nibbles. The bench gets there by loading F into each nibble, then issuing one high lookup and checking both the returned nibble and the 000h pointer. A second hard case is when a nibble load and a high lookup arrive in the same cycle. That case is driven directly. The sticky flag is checked after the bank code has returned to a legal value.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int PC_W   = 13;
  localparam int OFF_W  = 12;
  localparam int BANK_W = 2;
  localparam int ADDR_W = OFF_W + BANK_W;
  localparam int NIB_W  = 4;
  localparam int NNIB   = OFF_W / NIB_W;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_LO = 2'd1, ACC_HI = 2'd2} acc_e;
endpackage

// File: rtl/pbm_bank_reg.sv
module pbm_bank_reg
  import pbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wd,
  output logic [BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0] upper_bank,
  output logic              err_q
);
  logic [BANK_W-1:0] bank_d;
  logic              err_d;
  localparam logic [BANK_W-1:0] RSVD = {BANK_W{1'b1}};

  always_comb begin
    bank_d = bank_q;
    if (we) bank_d = wd;
    err_d = err_q | (bank_q == RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bank_q <= bank_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    if (bank_q == RSVD) upper_bank = RSVD;
    else                upper_bank = bank_q + 1'b1;
  end
endmodule

// File: rtl/pbm_dptr.sv
module pbm_dptr
  import pbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NNIB-1:0]  ld,
  input  logic [NIB_W-1:0] wd,
  input  logic             inc,
  output logic [OFF_W-1:0] dptr_q
);
  logic [OFF_W-1:0] inc_val;
  logic [OFF_W-1:0] dptr_d;

  assign inc_val = dptr_q + 1'b1;

  generate
    for (genvar g = 0; g < NNIB; g++) begin : g_nib
      always_comb begin
        if (ld[g])    dptr_d[g*NIB_W +: NIB_W] = wd;
        else if (inc) dptr_d[g*NIB_W +: NIB_W] = inc_val[g*NIB_W +: NIB_W];
        else          dptr_d[g*NIB_W +: NIB_W] = dptr_q[g*NIB_W +: NIB_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dptr_q <= '0;
    else        dptr_q <= dptr_d;
  end
endmodule

// File: rtl/pbm_lookup.sv
module pbm_lookup
  import pbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [BYTE_W-1:0] rdata,
  output acc_e              acc,
  output logic [NIB_W-1:0]  nib_q
);
  logic [NIB_W-1:0] nib_d;
  logic             nib_en;

  always_comb begin
    if (rd_hi)      acc = ACC_HI;
    else if (rd_lo) acc = ACC_LO;
    else            acc = ACC_NONE;
  end

  always_comb begin
    nib_en = (acc != ACC_NONE);
    nib_d  = (acc == ACC_HI) ? rdata[BYTE_W-1 -: NIB_W] : rdata[NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nib_q <= '0;
    else if (nib_en) nib_q <= nib_d;
  end
endmodule

// File: rtl/prog_bank_mapper.sv
module prog_bank_mapper
  import pbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] pc,
  input  logic        bank_we,
  input  logic [1:0]  bank_wd,
  output logic [1:0]  bank_q,
  output logic        err_rsvd,
  input  logic        dp_ld_lo,
  input  logic        dp_ld_mid,
  input  logic        dp_ld_hi,
  input  logic [3:0]  dp_wd,
  output logic [11:0] dptr_q,
  input  logic        rd_lo,
  input  logic        rd_hi,
  output logic [13:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [3:0]  nib_q
);
  logic [BANK_W-1:0] upper_bank;
  acc_e              acc;

  pbm_bank_reg u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wd(bank_wd),
    .bank_q(bank_q), .upper_bank(upper_bank), .err_q(err_rsvd)
  );

  pbm_dptr u_dptr (
    .clk(clk), .rst_n(rst_n), .ld({dp_ld_hi, dp_ld_mid, dp_ld_lo}),
    .wd(dp_wd), .inc(acc == ACC_HI), .dptr_q(dptr_q)
  );

  pbm_lookup u_look (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .rdata(mem_rdata), .acc(acc), .nib_q(nib_q)
  );

  always_comb begin
    if (acc != ACC_NONE)    mem_addr = {upper_bank, dptr_q};
    else if (pc[PC_W-1])    mem_addr = {upper_bank, pc[OFF_W-1:0]};
    else                    mem_addr = {{BANK_W{1'b0}}, pc[OFF_W-1:0]};
  end
endmodule

// File: rtl/prog_bank_mapper_chk.sv
module prog_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [12:0] pc,
  input logic        bank_we,
  input logic [1:0]  bank_wd,
  input logic [1:0]  bank_q,
  input logic        err_rsvd,
  input logic        dp_ld_lo,
  input logic        dp_ld_mid,
  input logic        dp_ld_hi,
  input logic [11:0] dptr_q,
  input logic        rd_lo,
  input logic        rd_hi,
  input logic [13:0] mem_addr,
  input logic [7:0]  mem_rdata,
  input logic [3:0]  nib_q
);
  logic any_ld;
  assign any_ld = dp_ld_lo | dp_ld_mid | dp_ld_hi;

  AST_LOW_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi && !pc[12]) |-> (mem_addr[13:12] == 2'b00)); // R2
  AST_UPPER_NOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi && pc[12]) |-> (mem_addr[13:12] != 2'b00)); // R3
  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q == $past(bank_wd))); // R4
  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsvd |=> err_rsvd); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && !any_ld) |=> $stable(dptr_q)); // R8
  AST_LO_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> (nib_q == $past(mem_rdata[3:0]))); // R8
  AST_HI_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !any_ld) |=> (dptr_q == $past(dptr_q) + 12'd1)); // R9
  AST_HI_NIB: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (nib_q == $past(mem_rdata[7:4]))); // R9
endmodule

bind prog_bank_mapper prog_bank_mapper_chk i_chk (.*);

// File: tb/test_prog_bank_mapper.sv
module test_prog_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] pc;
  logic        bank_we;
  logic [1:0]  bank_wd;
  logic [1:0]  bank_q;
  logic        err_rsvd;
  logic        dp_ld_lo, dp_ld_mid, dp_ld_hi;
  logic [3:0]  dp_wd;
  logic [11:0] dptr_q;
  logic        rd_lo, rd_hi;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [3:0]  nib_q;
  logic [7:0]  mem [0:16383];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  always_comb mem_rdata = mem[mem_addr];

  prog_bank_mapper i_prog_bank_mapper (.*);

  typedef struct packed {
    logic [1:0]  bank;
    logic [12:0] pc;
    logic [13:0] exp;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 13'h0000, 14'h0000},
    '{2'b00, 13'h0ABC, 14'h0ABC},
    '{2'b01, 13'h0FFF, 14'h0FFF},
    '{2'b00, 13'h1000, 14'h1000},
    '{2'b00, 13'h1777, 14'h1777},
    '{2'b01, 13'h1777, 14'h2777},
    '{2'b10, 13'h1FFF, 14'h3FFF},
    '{2'b10, 13'h0123, 14'h0123}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bank_we = 0; dp_ld_lo = 0; dp_ld_mid = 0; dp_ld_hi = 0;
    rd_lo = 0; rd_hi = 0;
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk); bank_we = 1; bank_wd = b;
    @(negedge clk); bank_we = 0;
  endtask

  task automatic load_dp(input logic [11:0] v);
    @(negedge clk); dp_ld_lo = 1; dp_wd = v[3:0];
    @(negedge clk); dp_ld_lo = 0; dp_ld_mid = 1; dp_wd = v[7:4];
    @(negedge clk); dp_ld_mid = 0; dp_ld_hi = 1; dp_wd = v[11:8];
    @(negedge clk); dp_ld_hi = 0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 8'(i ^ (i >> 8));
    mem[14'h2777] = 8'h56;
    mem[14'h3FFF] = 8'hA9;
    mem[14'h3000] = 8'h3C;
    idle(); pc = '0; bank_wd = '0; dp_wd = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bank", bank_q, 0);
    chk("R1 err", err_rsvd, 0);
    chk("R1 dptr", dptr_q, 0);
    chk("R1 nib", nib_q, 0);

    for (int i = 0; i < NV; i++) begin
      set_bank(VEC[i].bank);
      chk("R4 bank readback", bank_q, VEC[i].bank);
      pc = VEC[i].pc;
      #1;
      chk(VEC[i].pc[12] ? "R3 upper map" : "R2 lower map", mem_addr, VEC[i].exp);
    end

    load_dp(12'h777);
    chk("R6 dptr load", dptr_q, 12'h777);
    @(negedge clk); dp_ld_mid = 1; dp_wd = 4'h2;
    @(negedge clk); dp_ld_mid = 0;
    chk("R6 mid only", dptr_q, 12'h727);
    load_dp(12'h777);

    set_bank(2'b01);
    @(negedge clk); rd_lo = 1; #1;
    chk("R7 lookup addr", mem_addr, 14'h2777);
    @(negedge clk); rd_lo = 0;
    chk("R8 low nibble", nib_q, 4'h6);
    chk("R8 dptr held", dptr_q, 12'h777);
    @(negedge clk); rd_hi = 1;
    @(negedge clk); rd_hi = 0;
    chk("R9 high nibble", nib_q, 4'h5);
    chk("R9 dptr inc", dptr_q, 12'h778);

    set_bank(2'b10);
    load_dp(12'hFFF);
    @(negedge clk); rd_hi = 1; #1;
    chk("R7 bank3 addr", mem_addr, 14'h3FFF);
    @(negedge clk); rd_hi = 0;
    chk("R10 nib", nib_q, 4'hA);
    chk("R10 wrap", dptr_q, 12'h000);

    load_dp(12'hFFF);
    @(negedge clk); rd_hi = 1; rd_lo = 1;
    @(negedge clk); rd_hi = 0; rd_lo = 0;
    chk("R11 hi wins nib", nib_q, 4'hA);
    chk("R11 hi wins inc", dptr_q, 12'h000);
    load_dp(12'h0FF);
    @(negedge clk); rd_hi = 1; dp_ld_hi = 1; dp_wd = 4'h5;
    @(negedge clk); rd_hi = 0; dp_ld_hi = 0;
    chk("R11 load over inc", dptr_q, 12'h500);

    set_bank(2'b11);
    pc = 13'h1000; #1;
    chk("R5 rsvd maps bank3", mem_addr, 14'h3000);
    @(negedge clk);
    chk("R5 err set", err_rsvd, 1);
    set_bank(2'b00);
    @(negedge clk);
    chk("R5 err sticky", err_rsvd, 1);
    #1;
    chk("R3 after rsvd", mem_addr, 14'h1000);

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 err cleared", err_rsvd, 0);
    chk("R1 bank cleared", bank_q, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule